// File: doc/BRIEF.md
# Reference-Embedded Ones-Counting Tree

This block counts the positions where an incoming bit vector and a stored reference vector are both one. Such a count is the binary dot product between the two vectors. The two reference vectors are not fetched from a memory. They live in shift registers placed beside the leaves of the counting tree. Every leaf takes three input bits, masks them with three reference bits from the chosen bank and produces a 2-bit partial sum. A pipelined binary adder tree then reduces the partial sums to a single count.

Software or a neighbouring block loads a reference by shifting it in one bit per cycle. A bank-select line steers each shift to one of the two banks. Each input vector carries its own bank select, and that select is registered together with the vector. A stream can therefore alternate between the two references from one cycle to the next. An input presented during a shift cycle is dropped and never produces a valid result.

Top module: `ref_count_tree`

## Requirements
- R1: After reset, outValid is low, and both reference banks hold all zeros, so every valid result is 0 until a bank is loaded.
- R2: An input accepted in cycle c yields outValid high exactly 2+ceil(log2(IN_WIDTH/3)) clock edges later, which is 5 at the default width of 24. Back-to-back inputs each produce one result.
- R3: With inSel = 0, countOut equals the number of bit positions where inVec and reference bank A are both 1.
- R4: With inSel = 1, countOut equals the number of positions where inVec and reference bank B are both 1.
- R5: The bank select travels with its own input vector. When inSel alternates on consecutive inputs, every result uses the bank that was selected for that input.
- R6: Each cycle with refLoadEn high shifts refLoadBit into bit IN_WIDTH-1 of the bank named by refLoadBank (0 = A, 1 = B) and moves that bank down by one bit. After IN_WIDTH shifts, the first bit shifted in sits at bit 0. The other bank is unchanged.
- R7: An input with inValid high in a cycle where refLoadEn is high produces no valid result.
- R8: A valid result reflects every reference shift made before its input cycle. A shift made in a later cycle does not alter it.
- R9: With an all-ones input and an all-ones reference, the count reaches IN_WIDTH, and a count never exceeds IN_WIDTH.
- R10: A cycle with inValid low produces no valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input vector present this cycle |
| inVec | input | IN_WIDTH | Input bit vector |
| inSel | input | 1 | Reference bank for this input (0 = A, 1 = B) |
| refLoadEn | input | 1 | Shift one reference bit this cycle |
| refLoadBank | input | 1 | Bank to shift (0 = A, 1 = B) |
| refLoadBit | input | 1 | Serial reference bit |
| outValid | output | 1 | countOut holds a result |
| countOut | output | ceil(log2(IN_WIDTH+1)) | Number of matching ones |

## Verification
Two functions can fall in the same cycle: a reference shift and the acceptance of an input vector. Shifts also land in the cycle right after an accepted input, while that input is still in the leaf stage. The bench provokes both cases with directed sequences and by scattering shifts through a random stream of vectors and selects. A reference model judges each result. It applies shifts only after it has computed the count of the input from the same cycle, and it expects no valid result for inputs that coincide with a shift.

// File: rtl/rct_pkg.sv
package rct_pkg;
  typedef struct packed {
    logic shiftA;   // shift bank A this cycle
    logic shiftB;   // shift bank B this cycle
    logic capture;  // accept the input vector as a valid item
  } rct_strobe_t;
endpackage

// File: rtl/rct_leaf.sv
module rct_leaf (
  input  logic [2:0] dataBits,
  input  logic [2:0] refBitsA,
  input  logic [2:0] refBitsB,
  input  logic       sel,
  output logic [1:0] leafSum
);
  logic [2:0] masked;

  always_comb begin
    masked  = dataBits & (sel ? refBitsB : refBitsA);
    leafSum = {1'b0, masked[0]} + {1'b0, masked[1]} + {1'b0, masked[2]};
  end
endmodule

// File: rtl/rct_ctrl.sv
module rct_ctrl
  import rct_pkg::*;
#(
  parameter int LAT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        refLoadEn,
  input  logic        refLoadBank,
  output rct_strobe_t strb,
  output logic        outValid
);
  logic [LAT-1:0] validPipe;

  always_comb begin
    strb.shiftA  = refLoadEn & ~refLoadBank;
    strb.shiftB  = refLoadEn & refLoadBank;
    strb.capture = inValid & ~refLoadEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[LAT-2:0], strb.capture};
  end

  assign outValid = validPipe[LAT-1];
endmodule

// File: rtl/rct_datapath.sv
module rct_datapath
  import rct_pkg::*;
#(
  parameter int W    = 24,
  parameter int CW   = 5,
  parameter int LVLS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  rct_strobe_t strb,
  input  logic [W-1:0] inVec,
  input  logic        inSel,
  input  logic        refLoadBit,
  output logic [CW-1:0] countOut
);
  localparam int NLEAF = W / 3;
  localparam int NP2   = 1 << LVLS;

  logic [W-1:0] refA, refB;
  logic [W-1:0] stVec;
  logic         stSel;
  logic [1:0]   leafSum [NLEAF];

  // reference shift registers kept next to the leaves
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refA <= '0;
      refB <= '0;
    end else begin
      if (strb.shiftA) refA <= {refLoadBit, refA[W-1:1]};
      if (strb.shiftB) refB <= {refLoadBit, refB[W-1:1]};
    end
  end

  // input vector and its bank select registered together
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stVec <= '0;
      stSel <= 1'b0;
    end else begin
      stVec <= inVec;
      stSel <= inSel;
    end
  end

  for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
    rct_leaf u_leaf (
      .dataBits(stVec[3*i +: 3]),
      .refBitsA(refA[3*i +: 3]),
      .refBitsB(refB[3*i +: 3]),
      .sel     (stSel),
      .leafSum (leafSum[i])
    );
  end

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    logic [CW-1:0] sum [NP2 >> l];
    if (l == 0) begin : g_base
      always_ff @(posedge clk) begin
        for (int i = 0; i < NP2; i++) begin
          if (!rstN || i >= NLEAF) sum[i] <= '0;
          else                     sum[i] <= CW'(leafSum[i]);
        end
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        for (int i = 0; i < (NP2 >> l); i++) begin
          if (!rstN) sum[i] <= '0;
          else       sum[i] <= g_lvl[l-1].sum[2*i] + g_lvl[l-1].sum[2*i+1];
        end
      end
    end
  end

  assign countOut = g_lvl[LVLS].sum[0];
endmodule

// File: rtl/ref_count_tree.sv
module ref_count_tree
  import rct_pkg::*;
#(
  parameter  int IN_WIDTH = 24,
  localparam int CNT_W    = $clog2(IN_WIDTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [IN_WIDTH-1:0] inVec,
  input  logic                inSel,
  input  logic                refLoadEn,
  input  logic                refLoadBank,
  input  logic                refLoadBit,
  output logic                outValid,
  output logic [CNT_W-1:0]    countOut
);
  localparam int NLEAF = IN_WIDTH / 3;
  localparam int LVLS  = (NLEAF > 1) ? $clog2(NLEAF) : 0;
  localparam int LAT   = 2 + LVLS;

  rct_strobe_t strb;

  rct_ctrl #(.LAT(LAT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .refLoadEn  (refLoadEn),
    .refLoadBank(refLoadBank),
    .strb       (strb),
    .outValid   (outValid)
  );

  rct_datapath #(.W(IN_WIDTH), .CW(CNT_W), .LVLS(LVLS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inVec     (inVec),
    .inSel     (inSel),
    .refLoadBit(refLoadBit),
    .countOut  (countOut)
  );
endmodule

// File: rtl/rct_checker.sv
module rct_checker
  import rct_pkg::*;
#(
  parameter int W   = 24,
  parameter int LAT = 5,
  parameter int CW  = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          refLoadEn,
  input logic          outValid,
  input logic [CW-1:0] countOut,
  input rct_strobe_t   strb
);
  logic [LAT-1:0] expPipe;

  always_ff @(posedge clk) begin
    if (!rstN) expPipe <= '0;
    else       expPipe <= {expPipe[LAT-2:0], inValid & ~refLoadEn};
  end

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == expPipe[LAT-1]);

  p_count_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (countOut <= CW'(W)));

  p_load_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    refLoadEn |-> !strb.capture);

  p_one_bank_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftA, strb.shiftB}) && ((strb.shiftA | strb.shiftB) == refLoadEn));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> !strb.capture);
endmodule

bind ref_count_tree rct_checker #(.W(IN_WIDTH), .LAT(LAT), .CW(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .refLoadEn(refLoadEn),
  .outValid (outValid),
  .countOut (countOut),
  .strb     (strb)
);

// File: tb/ref_count_tree_tb.sv
module ref_count_tree_tb;
  localparam int W   = 24;
  localparam int CW  = 5;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] inVec = '0;
  logic inSel = 1'b0;
  logic refLoadEn = 1'b0;
  logic refLoadBank = 1'b0;
  logic refLoadBit = 1'b0;
  logic outValid;
  logic [CW-1:0] countOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] mA = '0, mB = '0;
  logic         pV [LAT];
  int           pC [LAT];
  string        pT [LAT];

  always #10 clk = ~clk;

  ref_count_tree #(.IN_WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inVec(inVec), .inSel(inSel),
    .refLoadEn(refLoadEn), .refLoadBank(refLoadBank), .refLoadBit(refLoadBit),
    .outValid(outValid), .countOut(countOut)
  );

  function automatic int pop(logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic step(input logic v, input logic [W-1:0] vec, input logic sel,
                      input logic ld, input logic bank, input logic bt, input string tag);
    string vt;
    inValid = v; inVec = vec; inSel = sel;
    refLoadEn = ld; refLoadBank = bank; refLoadBit = bt;
    @(posedge clk);
    for (int i = LAT-1; i > 0; i--) begin
      pV[i] = pV[i-1]; pC[i] = pC[i-1]; pT[i] = pT[i-1];
    end
    pV[0] = v && !ld;
    pC[0] = pop(vec & (sel ? mB : mA));
    pT[0] = (v && ld) ? "R7" : (!v ? "R10" : tag);
    if (ld && !bank) mA = {bt, mA[W-1:1]};
    if (ld && bank)  mB = {bt, mB[W-1:1]};
    @(negedge clk);
    vt = (pT[LAT-1] == "R7" || pT[LAT-1] == "R10" || pT[LAT-1] == "R1") ? pT[LAT-1] : "R2";
    total++;
    if (outValid !== pV[LAT-1]) begin
      bad++;
      $display("FAIL %s outValid act=%0b exp=%0b", vt, outValid, pV[LAT-1]);
    end
    if (pV[LAT-1]) begin
      total++;
      if (countOut !== CW'(pC[LAT-1])) begin
        bad++;
        $display("FAIL %s countOut act=%0d exp=%0d", pT[LAT-1], countOut, pC[LAT-1]);
      end
    end
  endtask

  task automatic load(input logic bank, input logic [W-1:0] val, input string tag);
    for (int i = 0; i < W; i++) step(1'b0, '0, 1'b0, 1'b1, bank, val[i], tag);
  endtask

  task automatic drain();
    for (int i = 0; i < LAT; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rv;
    logic rs;
    void'($urandom(32'd4242));
    for (int i = 0; i < LAT; i++) begin pV[i] = 1'b0; pC[i] = 0; pT[i] = "R1"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (outValid !== 1'b0) begin bad++; $display("FAIL R1 outValid act=%0b exp=0", outValid); end
    rstN = 1'b1;

    // R1: references are zero after reset
    step(1'b1, '1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, '1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    drain();

    // R6: bit order, first shifted bit ends at bit 0; bank B untouched
    load(1'b0, W'(1), "R6");
    step(1'b1, W'(1), 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, W'(1) << (W-1), 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, '1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    drain();

    // R9: full count
    load(1'b0, '1, "R9");
    load(1'b1, '1, "R9");
    step(1'b1, '1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b1, '1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    drain();

    // R5: alternating select on back-to-back inputs
    load(1'b0, 24'hF0F0F0, "R6");
    load(1'b1, 24'h0F0F3F, "R6");
    for (int i = 0; i < 8; i++)
      step(1'b1, 24'hFFFF00 ^ W'(i * 24'h111111), 1'(i), 1'b0, 1'b0, 1'b0, "R5");
    drain();

    // R8: shift the bank in the cycle right after an input
    step(1'b1, '1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    step(1'b1, '1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // R7: input together with a shift
    step(1'b1, '1, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    drain();

    // random mix: inputs, idle cycles and scattered shifts
    for (int n = 0; n < 600; n++) begin
      rv = W'($urandom());
      rs = 1'($urandom());
      case ($urandom_range(0, 9))
        0:       step(1'b0, rv, rs, 1'b0, 1'b0, 1'b0, "R10");
        1, 2:    step(1'($urandom()), rv, rs, 1'b1, 1'($urandom()), 1'($urandom()), "R8");
        default: step(1'b1, rv, rs, 1'b0, 1'b0, 1'b0, rs ? "R4" : "R3");
      endcase
    end
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule